// File: doc/BRIEF.md
# I2C Receive-Done Interrupt Handshake

This block is the interrupt status and receive flow-control logic for a set of buses in an I2C master controller. For every bus it keeps a 15-bit event status register that software clears by writing ones. It also keeps a 15-bit enable register and a small command register. Through the command register software asks for one received byte at a time. A separate byte engine does the bit-level work. The block tells that engine when to fetch a byte. The engine answers with a strobe and the byte.

The receive-done event is a handshake. When a fetched byte arrives, the block latches it and raises the receive-done flag. The flag stays up until software writes a one to it. While the flag is set, any further receive command is held back. When software clears the flag, a held command is launched on the same clock edge, and the interrupt comes back once the new byte lands. Each bus reduces its enabled status to one summary bit. The summaries form a controller-level status vector, and a single interrupt line is their OR.

Top module: `i2c_rxdone_irq`

## Requirements
- R1: After synchronous reset, all status, enable, pending-command and data registers read zero, and `rx_start`, `rx_last`, `bus_irq` and `irq` are low.
- R2: A write to the status register (address 2) clears each status bit whose written bit is 1, over bits 14..0 only. Bits written as 0 keep their value.
- R3: A write to the enable register (address 1) stores bits 14..0. Bit 15 is dropped and reads back as 0.
- R4: Bit 2 of the status register is the receive-done flag. It is set only by an accepted byte. Bit 2 of the `evt` input is ignored, and every other `evt` bit sets its status bit on the edge where it is high.
- R5: The receive-done flag is never cleared by hardware or by reading the data register (address 3). Only a status write with bit 2 set clears it.
- R6: Command bit 0 (receive) and bit 1 (receive-last) are held pending while the receive-done flag is set. While pending, they read back at address 0 and no `rx_start` is issued.
- R7: A status write with bit 2 set that clears a set flag while a command is pending raises `rx_start` on that same edge. `rx_last` equals the pending receive-last bit, and the interrupt rises again once the new byte is accepted.
- R8: A status write with bit 2 set while the flag is already clear changes nothing and starts no reception.
- R9: If a byte is accepted on the same edge as a software clear of bit 2, the flag ends at 1.
- R10: The data register loads the byte on the edge the flag is set. It stays unchanged until the flag is cleared.
- R11: `bus_irq[b]` equals the OR of (status AND enable) of bus b, one cycle after the status or enable value. `irq` equals the OR of `bus_irq` one cycle later.
- R12: The register map has the pending commands at address 0, enable at 1, status at 2 and data at 3. `reg_bus` selects the bus, and a read returns its value in `reg_rdata` on the following edge.
- R13: With the flag clear and no fetch outstanding, a command write leads to a one-cycle `rx_start` on the second edge after the write. An `rx_valid` strobe with no fetch outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_bus | input | BSW | Bus select |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| rx_start | output | NBUS | Per-bus fetch request pulse to the byte engine |
| rx_last | output | NBUS | Fetch is the final byte |
| rx_valid | input | NBUS | Byte engine delivers a byte |
| rx_data | input | NBUS*8 | Delivered bytes, bus b at bits 8b+7..8b |
| evt | input | NBUS*15 | Other status event pulses, bus b at bits 15b+14..15b |
| bus_irq | output | NBUS | Per-bus summary, shared controller status |
| irq | output | 1 | Controller interrupt line |

## Verification
Two things can hit receive-done in the same cycle: a byte arriving from the engine and a software write that clears bit 2. The bench drives `rx_valid` and a status write of 0x0004 on the same edge while a fetch is outstanding. It then reads the status back and expects bit 2 still set and the new byte in the data register. Random phases also mix event pulses with clearing writes in the same cycle, and a bench model in which the set wins judges the result.

// File: rtl/i2c_rxirq_pkg.sv
package i2c_rxirq_pkg;
  localparam int STS_W      = 15;
  localparam int DONE_BIT   = 2;
  localparam int CMD_RX     = 0;
  localparam int CMD_RXLAST = 1;

  typedef enum logic [1:0] {
    ADR_CMD  = 2'd0,
    ADR_IEN  = 2'd1,
    ADR_STS  = 2'd2,
    ADR_DATA = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
  parameter int STS_W    = 15,
  parameter int DONE_BIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sts_we,
  input  logic             en_we,
  input  logic [STS_W-1:0] wdata,
  input  logic [STS_W-1:0] evt,
  input  logic             done_set,
  output logic [STS_W-1:0] sts_q,
  output logic [STS_W-1:0] en_q,
  output logic             done_nxt,
  output logic             sum_q
);
  localparam logic [STS_W-1:0] DONE_MASK = STS_W'(1) << DONE_BIT;

  logic [STS_W-1:0] clr_v;
  logic [STS_W-1:0] set_v;
  logic [STS_W-1:0] sts_nxt;

  always_comb begin
    clr_v    = sts_we ? wdata : '0;
    set_v    = (evt & ~DONE_MASK) | (done_set ? DONE_MASK : '0);
    sts_nxt  = (sts_q & ~clr_v) | set_v;
    done_nxt = sts_nxt[DONE_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
      sum_q <= 1'b0;
    end else begin
      sts_q <= sts_nxt;
      if (en_we) en_q <= wdata;
      sum_q <= |(sts_q & en_q);
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sts_q[DONE_BIT] && !(sts_we && wdata[DONE_BIT])) |=> sts_q[DONE_BIT]); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    done_set |=> sts_q[DONE_BIT]); // R9
  AST_SUM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sts_q == '0) |=> !sum_q); // R11
endmodule

// File: rtl/rx_fetch_gate.sv
module rx_fetch_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [1:0]    cmd_bits,
  input  logic          done_q,
  input  logic          done_nxt,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic [1:0]    pend_q,
  output logic          start_q,
  output logic          last_q,
  output logic          done_set,
  output logic [DW-1:0] data_q
);
  logic       busy_q;
  logic       start;
  logic [1:0] new_cmd;

  always_comb begin
    new_cmd  = cmd_we ? cmd_bits : 2'b00;
    start    = (|pend_q) && !busy_q && !done_nxt;
    done_set = rx_valid && busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      last_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      pend_q  <= start ? new_cmd : (pend_q | new_cmd);
      start_q <= start;
      last_q  <= start && pend_q[1];
      if (start)         busy_q <= 1'b1;
      else if (done_set) busy_q <= 1'b0;
      if (done_set)      data_q <= rx_data;
    end
  end

  AST_NO_START_WHILE_DONE: assert property (@(posedge clk) disable iff (rst)
    start_q |-> !done_q); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done_q && done_nxt) |=> $stable(data_q)); // R10
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !busy_q) |=> $stable(data_q)); // R13
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q); // R13
endmodule

// File: rtl/i2c_rxdone_irq.sv
module i2c_rxdone_irq
  import i2c_rxirq_pkg::*;
#(
  parameter int NBUS  = 2,
  parameter int DW    = 8,
  parameter int REG_W = 16,
  parameter int BSW   = (NBUS > 1) ? $clog2(NBUS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [BSW-1:0]      reg_bus,
  input  logic [1:0]          reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NBUS-1:0]     rx_start,
  output logic [NBUS-1:0]     rx_last,
  input  logic [NBUS-1:0]     rx_valid,
  input  logic [NBUS*DW-1:0]  rx_data,
  input  logic [NBUS*STS_W-1:0] evt,
  output logic [NBUS-1:0]     bus_irq,
  output logic                irq
);
  logic [STS_W-1:0] sts_a  [NBUS];
  logic [STS_W-1:0] en_a   [NBUS];
  logic [1:0]       pend_a [NBUS];
  logic [DW-1:0]    data_a [NBUS];
  logic             unused_hi;

  assign unused_hi = ^reg_wdata[REG_W-1:STS_W];

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    logic sel, done_nxt, done_set;

    assign sel = (int'(reg_bus) == g);

    irq_status_regs #(.STS_W(STS_W), .DONE_BIT(DONE_BIT)) u_sts (
      .clk      (clk),
      .rst      (rst),
      .sts_we   (reg_we && sel && (reg_addr == ADR_STS)),
      .en_we    (reg_we && sel && (reg_addr == ADR_IEN)),
      .wdata    (reg_wdata[STS_W-1:0]),
      .evt      (evt[g*STS_W +: STS_W]),
      .done_set (done_set),
      .sts_q    (sts_a[g]),
      .en_q     (en_a[g]),
      .done_nxt (done_nxt),
      .sum_q    (bus_irq[g])
    );

    rx_fetch_gate #(.DW(DW)) u_gate (
      .clk      (clk),
      .rst      (rst),
      .cmd_we   (reg_we && sel && (reg_addr == ADR_CMD)),
      .cmd_bits ({reg_wdata[CMD_RXLAST], reg_wdata[CMD_RX]}),
      .done_q   (sts_a[g][DONE_BIT]),
      .done_nxt (done_nxt),
      .rx_valid (rx_valid[g]),
      .rx_data  (rx_data[g*DW +: DW]),
      .pend_q   (pend_a[g]),
      .start_q  (rx_start[g]),
      .last_q   (rx_last[g]),
      .done_set (done_set),
      .data_q   (data_a[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |bus_irq;
      if (reg_re) begin
        reg_rdata <= '0;
        if (int'(reg_bus) < NBUS) begin
          case (reg_addr)
            ADR_CMD:  reg_rdata <= REG_W'(pend_a[reg_bus]);
            ADR_IEN:  reg_rdata <= REG_W'(en_a[reg_bus]);
            ADR_STS:  reg_rdata <= REG_W'(sts_a[reg_bus]);
            default:  reg_rdata <= REG_W'(data_a[reg_bus]);
          endcase
        end
      end
    end
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|bus_irq) |=> irq); // R11
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
    !(|bus_irq) |=> !irq); // R11
endmodule

// File: tb/i2c_rxdone_irq_bench.sv
module i2c_rxdone_irq_bench;
  localparam int NBUS = 2;
  localparam int SW   = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0, reg_re = 1'b0;
  logic [0:0]        reg_bus = '0;
  logic [1:0]        reg_addr = '0;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;
  logic [NBUS-1:0]   rx_start, rx_last, bus_irq;
  logic [NBUS-1:0]   rx_valid = '0;
  logic [NBUS*8-1:0] rx_data = '0;
  logic [NBUS*SW-1:0] evt = '0;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [SW-1:0] m_sts [NBUS];
  logic [SW-1:0] m_en  [NBUS];

  always #2.5 clk = ~clk;

  i2c_rxdone_irq u_i2c_rxdone_irq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_bus(reg_bus),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_start(rx_start), .rx_last(rx_last), .rx_valid(rx_valid), .rx_data(rx_data),
    .evt(evt), .bus_irq(bus_irq), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int b, input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_bus = 1'(b); reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input int b, input logic [1:0] a, output logic [15:0] d);
    reg_re = 1'b1; reg_bus = 1'(b); reg_addr = a;
    step();
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic deliver(input int b, input logic [7:0] v);
    rx_valid[b] = 1'b1; rx_data[b*8 +: 8] = v;
    step();
    rx_valid[b] = 1'b0;
  endtask

  function automatic logic [SW-1:0] model_next(input logic [SW-1:0] s,
      input logic [SW-1:0] ev, input logic [SW-1:0] clr);
    return (s & ~clr) | (ev & ~SW'(4));
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 bus_irq", bus_irq, 0);
    chk("R1 rx_start", rx_start, 0);
    rd(0, 2'd2, d); chk("R1 sts", d, 0);
    rd(0, 2'd1, d); chk("R1 en", d, 0);
    rd(0, 2'd3, d); chk("R1 data R12", d, 0);
    // R3 enable width
    wr(0, 2'd1, 16'hFFFF);
    rd(0, 2'd1, d); chk("R3 en low 15", d, 16'h7FFF);
    // R13 first command
    wr(0, 2'd0, 16'h0001);
    chk("R13 no start yet", rx_start[0], 0);
    step(); chk("R13 start", rx_start[0], 1); chk("R13 last", rx_last[0], 0);
    step(); chk("R13 pulse", rx_start[0], 0);
    deliver(0, 8'hA5);
    step(); chk("R11 bus_irq up", bus_irq[0], 1);
    step(); chk("R11 irq up", irq, 1);
    // R6 second command held
    wr(0, 2'd0, 16'h0002);
    for (int i = 0; i < 4; i++) begin
      chk("R6 held", rx_start[0], 0);
      step();
    end
    rd(0, 2'd0, d); chk("R6 pending R12", d, 16'h0002);
    deliver(0, 8'h3C);
    rd(0, 2'd3, d); chk("R10 R13 data held", d, 16'h00A5);
    rd(0, 2'd2, d); chk("R5 still set after read", d, 16'h0004);
    // R7 clear launches deferred receive
    wr(0, 2'd2, 16'h0004);
    chk("R7 start on clear", rx_start[0], 1);
    chk("R7 last", rx_last[0], 1);
    step(); chk("R11 bus_irq down", bus_irq[0], 0);
    step(); chk("R11 irq down", irq, 0);
    deliver(0, 8'h5A);
    step(); chk("R7 bus_irq again", bus_irq[0], 1);
    step(); chk("R7 irq again", irq, 1);
    rd(0, 2'd3, d); chk("R10 second byte", d, 16'h005A);
    // R8 clear with nothing pending / already clear
    wr(0, 2'd2, 16'h0004); chk("R8 no start", rx_start[0], 0);
    wr(0, 2'd2, 16'h0004); chk("R8 no start clear", rx_start[0], 0);
    step(); chk("R8 still idle", rx_start[0], 0);
    rd(0, 2'd2, d); chk("R8 sts", d, 0);
    rd(0, 2'd0, d); chk("R8 pend", d, 0);
    // R9 set wins
    wr(0, 2'd0, 16'h0001);
    step(); chk("R9 fetch started", rx_start[0], 1);
    reg_we = 1'b1; reg_bus = 1'b0; reg_addr = 2'd2; reg_wdata = 16'h0004;
    rx_valid[0] = 1'b1; rx_data[7:0] = 8'h77;
    step();
    reg_we = 1'b0; rx_valid[0] = 1'b0;
    rd(0, 2'd2, d); chk("R9 flag", d, 16'h0004);
    rd(0, 2'd3, d); chk("R9 data", d, 16'h0077);
    wr(0, 2'd2, 16'h0004);
    // R4 evt bit 2 ignored
    evt[2] = 1'b1; step(); evt = '0;
    rd(0, 2'd2, d); chk("R4 evt bit2", d, 0);
    evt[5] = 1'b1; step(); evt = '0;
    rd(0, 2'd2, d); chk("R4 evt bit5", d, 16'h0020);
    wr(0, 2'd2, 16'h0020);
    // R2 write-one-to-clear
    evt[SW-1:0] = 15'h7FFB; step(); evt = '0;
    rd(0, 2'd2, d); chk("R2 set", d, 16'h7FFB);
    wr(0, 2'd2, 16'h0011); rd(0, 2'd2, d); chk("R2 partial", d, 16'h7FEA);
    wr(0, 2'd2, 16'h0000); rd(0, 2'd2, d); chk("R2 zeros", d, 16'h7FEA);
    wr(0, 2'd2, 16'hFFFF); rd(0, 2'd2, d); chk("R2 all", d, 0);
    rd(1, 2'd2, d); chk("R12 bus1 untouched", d, 0);
    // random phase against model (R2 R3 R4 R11)
    m_sts[0] = '0; m_sts[1] = '0; m_en[0] = 15'h7FFF; m_en[1] = '0;
    for (int it = 0; it < 300; it++) begin
      int b, op;
      logic [15:0] w;
      logic [SW-1:0] ev0, ev1;
      b = int'($urandom % 2); op = int'($urandom % 3); w = 16'($urandom);
      ev0 = SW'($urandom & $urandom & $urandom);
      ev1 = SW'($urandom & $urandom & $urandom);
      evt = {ev1, ev0};
      if (op != 0) begin
        reg_we = 1'b1; reg_bus = 1'(b); reg_addr = (op == 1) ? 2'd2 : 2'd1; reg_wdata = w;
      end
      step();
      reg_we = 1'b0; evt = '0;
      for (int k = 0; k < NBUS; k++) begin
        logic [SW-1:0] clr;
        clr = (op == 1 && k == b) ? w[SW-1:0] : '0;
        m_sts[k] = model_next(m_sts[k], (k == 0) ? ev0 : ev1, clr);
        if (op == 2 && k == b) m_en[k] = w[SW-1:0];
      end
      rd(b, 2'd2, d); chk("R2 R4 random sts", d, 16'(m_sts[b]));
      chk("R11 random bus_irq", bus_irq,
          {|(m_sts[1] & m_en[1]), |(m_sts[0] & m_en[0])});
      step();
      chk("R11 random irq", irq, |((m_sts[1] & m_en[1]) | (m_sts[0] & m_en[0])));
      if (it % 10 == 0) begin
        rd(b, 2'd1, d); chk("R3 random en", d, 16'(m_en[b]));
      end
    end
    finish_run();
  end
endmodule